// File: doc/BRIEF.md
# SPI Master Serial Clock and Frame Shifter

This block is the master side of an SPI-style serial link. It makes the serial clock from the system clock with a programmable divider. An optional fixed prescaler can stretch the period further. The block shifts one word per frame out on MOSI, most significant bit first, and collects the word arriving on MISO at the same time. The slave select stays low for the whole frame.

A small control register holds the clock rest level, the clock phase, the prescaler enable and a 6-bit divide modulus. The register can be written only while the block is idle. Reset leaves the phase bit set and every other control bit clear. One setting of the register is illegal: prescaler on together with a modulus of zero. The block will not start a frame with that setting and raises an error flag instead.

A frame begins when `start` is pulsed while the block is idle. A one-cycle `done` pulse marks the end of the frame, and the received word is valid on `rx_byte` in that same cycle.

Top module: `spi_sck_master`

## Requirements
- R1: A synchronous reset sets the control register as follows: rest level 0, phase 1, prescaler 0, modulus 0. It also drives `ss_n` high, `sck` low, and `busy`, `done` and `cfg_err` low.
- R2: While no frame is in progress, `sck` rests at the level held in the rest-level bit: low for 0, high for 1. It also ends every frame at that level.
- R3: Each half-period of `sck` lasts H system clocks. H = (modulus + 1) × (8 if the prescaler is on, else 1), with a minimum of 2, so `sck` never runs faster than a quarter of the system clock.
- R4: A `start` pulse with the prescaler on and modulus 0 does not begin a frame and sets `cfg_err` to 1. A later `start` accepted with a legal setting clears `cfg_err` to 0.
- R5: An accepted frame drives `ss_n` low from the cycle after `start` until the cycle after the last clock edge. It produces exactly 16 `sck` edges and sends the 8 bits of `tx_byte` most significant bit first.
- R6: With phase 0, MOSI carries bit 7 as soon as `ss_n` falls. The slave samples on leading (odd-numbered from rest: 1st, 3rd, …) edges, and MOSI changes only on trailing edges.
- R7: With phase 1, MOSI changes on leading edges and is sampled on trailing edges. The master captures MISO on the trailing edges.
- R8: `done` is high for exactly one cycle, one system clock after the final `sck` edge. In that cycle `rx_byte` holds the 8 MISO bits (first-captured bit in bit 7), `ss_n` is high and `busy` is low.
- R9: A control register write is taken only in a cycle where `busy` and `start` are both low. A write in any other cycle leaves the register unchanged, and the unchanged value can be seen on the `ctl_*` outputs.
- R10: A `start` pulse while `busy` is high is ignored. The frame in flight completes with its original data and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_pol | input | 1 | Write data: clock rest level |
| cfg_pha | input | 1 | Write data: clock phase |
| cfg_pre | input | 1 | Write data: prescaler enable |
| cfg_div | input | 6 | Write data: divide modulus |
| start | input | 1 | Begin a frame when idle |
| tx_byte | input | 8 | Word to send |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 1 | Slave select, active low |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rx_byte | output | 8 | Received word |
| cfg_err | output | 1 | Last start refused for an illegal setting |
| ctl_pol | output | 1 | Control register: rest level |
| ctl_pha | output | 1 | Control register: phase |
| ctl_pre | output | 1 | Control register: prescaler enable |
| ctl_div | output | 6 | Control register: modulus |

## Verification
The bench builds the block with its default parameters: an 8-bit word, a 6-bit modulus and a prescaler shift of 3. With these values it can reach the clamp to a half-period of 2 (modulus 0 and 1), odd half-periods from plain division, prescaled half-periods of 16 and 24, and the largest unprescaled setting of 64. A model slave in the bench follows the `sck` edges to check both the phase rules and the received word. Frames that are disturbed by a mid-frame write, by a second start, and by a write in the start cycle show that the control register and the frame in flight are protected.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  localparam int DIV_W = 6;

  typedef struct packed {
    logic             pol;
    logic             pha;
    logic             pre;
    logic [DIV_W-1:0] div;
  } sck_cfg_t;

  localparam sck_cfg_t CFG_RESET = '{pol: 1'b0, pha: 1'b1, pre: 1'b0, div: '0};
endpackage

// File: rtl/spi_sck_ctrlreg.sv
module spi_sck_ctrlreg
  import spi_sck_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr,
  input  sck_cfg_t wr_cfg,
  input  logic     lock,
  output sck_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst)             cfg <= CFG_RESET;
    else if (wr && !lock) cfg <= wr_cfg;
  end
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import spi_sck_pkg::*;
#(
  parameter int PRE_SHIFT = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  logic     restart,
  input  sck_cfg_t cfg,
  output logic     tick
);
  localparam int HW = DIV_W + PRE_SHIFT + 1;

  logic [HW-1:0] base, half, cnt;

  always_comb begin
    base = HW'(cfg.div) + HW'(1);
    half = cfg.pre ? (base << PRE_SHIFT) : base;
    if (half < HW'(2)) half = HW'(2);
  end

  assign tick = run && (cnt == half - HW'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (run) cnt <= tick ? '0 : cnt + HW'(1);
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst) tick |=> !tick);
endmodule

// File: rtl/spi_sck_shifter.sv
module spi_sck_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [WORD_W-1:0] tx,
  input  logic              pol,
  input  logic              pha,
  input  logic              tick,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx
);
  localparam int EDGES = 2 * WORD_W;
  localparam int EW    = $clog2(EDGES);
  localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

  logic [EW-1:0]     edge_cnt;
  logic [WORD_W-1:0] sreg;
  logic              fin;
  logic              samp;

  assign samp = (~edge_cnt[0]) ^ pha;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck      <= 1'b0;
      mosi     <= 1'b0;
      ss_n     <= 1'b1;
      busy     <= 1'b0;
      done     <= 1'b0;
      rx       <= '0;
      sreg     <= '0;
      edge_cnt <= '0;
      fin      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck <= pol;
        if (launch) begin
          busy     <= 1'b1;
          ss_n     <= 1'b0;
          edge_cnt <= '0;
          fin      <= 1'b0;
          if (pha) begin
            sreg <= tx;
          end else begin
            mosi <= tx[WORD_W-1];
            sreg <= tx << 1;
          end
        end
      end else if (fin) begin
        fin  <= 1'b0;
        busy <= 1'b0;
        ss_n <= 1'b1;
        done <= 1'b1;
      end else if (tick) begin
        sck      <= ~sck;
        edge_cnt <= edge_cnt + EW'(1);
        if (samp) begin
          rx <= {rx[WORD_W-2:0], miso};
        end else if (edge_cnt != LAST) begin
          mosi <= sreg[WORD_W-1];
          sreg <= sreg << 1;
        end
        if (edge_cnt == LAST) fin <= 1'b1;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R5
  ss_active_chk: assert property (@(posedge clk) disable iff (rst) busy |-> !ss_n);
  // R2
  sck_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(pol)) |-> (sck == pol));
endmodule

// File: rtl/spi_sck_master.sv
module spi_sck_master
  import spi_sck_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int PRE_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_pol,
  input  logic              cfg_pha,
  input  logic              cfg_pre,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              ss_n,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_byte,
  output logic              cfg_err,
  output logic              ctl_pol,
  output logic              ctl_pha,
  output logic              ctl_pre,
  output logic [DIV_W-1:0]  ctl_div
);
  sck_cfg_t cfg, wr_cfg;
  logic     illegal, launch, tick;

  assign wr_cfg  = '{pol: cfg_pol, pha: cfg_pha, pre: cfg_pre, div: cfg_div};
  assign illegal = cfg.pre && (cfg.div == '0);
  assign launch  = start && !busy && !illegal;

  spi_sck_ctrlreg u_reg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wr_cfg(wr_cfg),
    .lock(busy || start), .cfg(cfg)
  );

  spi_sck_divider #(.PRE_SHIFT(PRE_SHIFT)) u_div (
    .clk(clk), .rst(rst), .run(busy), .restart(launch), .cfg(cfg), .tick(tick)
  );

  spi_sck_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst(rst), .launch(launch), .tx(tx_byte),
    .pol(cfg.pol), .pha(cfg.pha), .tick(tick), .miso(miso),
    .sck(sck), .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done), .rx(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else if (start && !busy) cfg_err <= illegal;
  end

  assign ctl_pol = cfg.pol;
  assign ctl_pha = cfg.pha;
  assign ctl_pre = cfg.pre;
  assign ctl_div = cfg.div;

  // R4
  illegal_start_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && ctl_pre && ctl_div == '0) |=> (!busy && cfg_err));
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(cfg));
endmodule

// File: tb/spi_sck_master_tb.sv
module spi_sck_master_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0, cfg_pol = 1'b0, cfg_pha = 1'b0, cfg_pre = 1'b0;
  logic [5:0] cfg_div = '0;
  logic       start = 1'b0;
  logic [7:0] tx_byte = '0;
  logic       miso = 1'b0;
  logic       sck, mosi, ss_n, busy, done, cfg_err;
  logic       ctl_pol, ctl_pha, ctl_pre;
  logic [5:0] ctl_div;
  logic [7:0] rx_byte;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  spi_sck_master u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_pol(cfg_pol), .cfg_pha(cfg_pha),
    .cfg_pre(cfg_pre), .cfg_div(cfg_div), .start(start), .tx_byte(tx_byte),
    .miso(miso), .sck(sck), .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done),
    .rx_byte(rx_byte), .cfg_err(cfg_err), .ctl_pol(ctl_pol), .ctl_pha(ctl_pha),
    .ctl_pre(ctl_pre), .ctl_div(ctl_div)
  );

  // {pol, pha, pre, div[5:0], tx[7:0], slave[7:0]}
  localparam logic [24:0] VECS [8] = '{
    {1'b0, 1'b0, 1'b0, 6'd0,  8'hA5, 8'h3C},
    {1'b0, 1'b1, 1'b0, 6'd1,  8'h81, 8'h7E},
    {1'b1, 1'b0, 1'b0, 6'd2,  8'h5A, 8'hC3},
    {1'b1, 1'b1, 1'b0, 6'd4,  8'h0F, 8'hF0},
    {1'b0, 1'b0, 1'b1, 6'd1,  8'hC6, 8'h19},
    {1'b1, 1'b1, 1'b1, 6'd2,  8'h37, 8'hE8},
    {1'b0, 1'b1, 1'b0, 6'd63, 8'hFF, 8'h01},
    {1'b1, 1'b0, 1'b0, 6'd0,  8'h00, 8'hAA}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic p, input logic h, input logic e, input logic [5:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_pol = p; cfg_pha = h; cfg_pre = e; cfg_div = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic run_frame(input logic p_pol, input logic p_pha, input logic p_pre,
                           input logic [5:0] p_div, input logic [7:0] p_tx,
                           input logic [7:0] p_sl, input bit disturb);
    int h, cyc, last, e, bad_per, ss_bad;
    logic prev;
    logic [7:0] got;
    bit dseen, samp;
    h = (int'(p_div) + 1) * (p_pre ? 8 : 1);
    if (h < 2) h = 2;
    write_cfg(p_pol, p_pha, p_pre, p_div);
    chk({ctl_pol, ctl_pha, ctl_pre, ctl_div} == {p_pol, p_pha, p_pre, p_div}, "R9 idle write",
        {ctl_pol, ctl_pha, ctl_pre, ctl_div}, {p_pol, p_pha, p_pre, p_div});
    @(negedge clk);
    chk(sck == p_pol, "R2 rest level", sck, p_pol);
    tx_byte = p_tx; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!ss_n && busy, "R5 frame open", {ss_n, busy}, 2'b01);
    if (!p_pha) chk(mosi == p_tx[7], "R6 first bit before edge", mosi, p_tx[7]);
    miso = p_sl[7];
    cyc = 0; last = 0; e = 0; prev = sck; got = '0; bad_per = 0; ss_bad = 0; dseen = 1'b0;
    while (!dseen && cyc < 5000) begin
      if (disturb && cyc == 3) begin
        cfg_wr = 1'b1; cfg_pol = ~p_pol; cfg_pha = ~p_pha; cfg_pre = 1'b0; cfg_div = 6'd9;
        start = 1'b1; tx_byte = ~p_tx;
      end else begin
        cfg_wr = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      cyc++;
      if (done) begin
        dseen = 1'b1;
        chk(cyc - last == 1, "R8 done timing", cyc - last, 1);
        chk(rx_byte == p_sl, "R8 rx word", rx_byte, p_sl);
        chk(ss_n && !busy, "R8 frame closed", {ss_n, busy}, 2'b10);
        chk(sck == p_pol, "R2 end level", sck, p_pol);
        chk(e == 16, "R5 edge count", e, 16);
        chk(bad_per == 0, "R3 half period", bad_per, 0);
        chk(ss_bad == 0, "R5 select held", ss_bad, 0);
        chk(got == p_tx, p_pha ? "R7 mosi word" : "R6 mosi word", got, p_tx);
      end else if (sck != prev) begin
        if (cyc - last != h) bad_per++;
        if (ss_n) ss_bad++;
        last = cyc;
        samp = ((e % 2) == 0) ^ p_pha;
        if (samp) got = {got[6:0], mosi};
        else if (e != 15) miso = p_pha ? p_sl[7 - e/2] : p_sl[7 - (e+1)/2];
        e++;
        prev = sck;
      end
    end
    chk(dseen, "R8 done seen", dseen, 1);
    @(negedge clk);
    chk(!done, "R8 single pulse", done, 0);
    if (disturb) begin
      chk({ctl_pol, ctl_pha, ctl_pre, ctl_div} == {p_pol, p_pha, p_pre, p_div}, "R9 busy write",
          {ctl_pol, ctl_pha, ctl_pre, ctl_div}, {p_pol, p_pha, p_pre, p_div});
      repeat (4) @(negedge clk);
      chk(ss_n && !busy, "R10 no second frame", {ss_n, busy}, 2'b10);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({ctl_pol, ctl_pha, ctl_pre, ctl_div} == 9'b010000000, "R1 control reset",
        {ctl_pol, ctl_pha, ctl_pre, ctl_div}, 9'b010000000);
    chk({ss_n, sck, busy, done, cfg_err} == 5'b10000, "R1 output reset",
        {ss_n, sck, busy, done, cfg_err}, 5'b10000);

    for (int i = 0; i < 8; i++) begin
      logic [24:0] v;
      v = VECS[i];
      run_frame(v[24], v[23], v[22], v[21:16], v[15:8], v[7:0], 1'b0);
    end

    // R4 illegal setting refused
    write_cfg(1'b0, 1'b0, 1'b1, 6'd0);
    tx_byte = 8'h99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(cfg_err && !busy && ss_n, "R4 illegal refused", {cfg_err, busy, ss_n}, 3'b101);
    repeat (5) @(negedge clk);
    chk(ss_n && sck == 1'b0, "R4 stays idle", {ss_n, sck}, 2'b10);
    run_frame(1'b0, 1'b0, 1'b1, 6'd0 + 6'd1, 8'h42, 8'h24, 1'b0);
    chk(!cfg_err, "R4 error cleared", cfg_err, 0);

    // R9 / R10 disturbed frame
    run_frame(1'b1, 1'b0, 1'b0, 6'd3, 8'hB4, 8'h6D, 1'b1);

    // R9 write in the start cycle
    write_cfg(1'b0, 1'b1, 1'b0, 6'd1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_pol = 1'b1; cfg_pha = 1'b0; cfg_pre = 1'b1; cfg_div = 6'd5;
    start = 1'b1; tx_byte = 8'h11;
    @(negedge clk);
    cfg_wr = 1'b0; start = 1'b0;
    chk({ctl_pol, ctl_pha, ctl_pre, ctl_div} == {1'b0, 1'b1, 1'b0, 6'd1}, "R9 start-cycle write",
        {ctl_pol, ctl_pha, ctl_pre, ctl_div}, {1'b0, 1'b1, 1'b0, 6'd1});
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    chk(!busy && ss_n, "R5 frame finished", {busy, ss_n}, 2'b01);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule